// File: doc/BRIEF.md
# Dual-Path Ping-Pong Clock Root Slice

The block derives one output clock from eight source clocks. Inside are two full selection paths, A and B. Each path has its own eight-way source select, its own enable gate and its own pre-divider. An OR of the two gated path clocks feeds a shared post-divider, and only one path is ever enabled at a time. Software never addresses a path. It writes a single target record through the register port: source index, gate enable, pre-divider value and post-divider value. The slice programs the idle path, disables the active path on that path's own clock and enables the newly programmed path on its own clock. The busy flag stays set until that handover ends.

The idle path's select register lives in the clock domain of the source it currently uses, so reprogramming it needs that source to be toggling. If software has stopped a source that an idle path still points at, the next write that lands on that path never finishes. Busy then stays high and the old path keeps driving the output. Writing the same target twice parks both paths on one source, which removes that hazard. A parameter builds a core variant without pre-dividers.

Top module: `clk_root_slice`

## Requirements
- R1: After reset both path selects hold source 0, path A is the active path, the gate is on and both divider fields are 0. Busy reads 1 only until path A's enable has settled, then 0. The read port then returns index 0, gate 1 and divider fields 0, and the output period equals the period of source 0.
- R2: A write accepted while busy is 0 sets busy from the next register-clock cycle. Busy stays set until the handover is done. Afterwards the read port returns the written index, gate and divider fields.
- R3: With the gate on, the output period is the selected source period times (pre + 1) times (post + 1). The pre field is 3 bits wide (divide by 1..8) and the post field is 6 bits wide (divide by 1..64).
- R4: A write presented while busy is 1 is dropped. The index, the fields and the output clock all stay as set by the write in progress.
- R5: A write loads its index only into the path that is not active. The active path keeps its select and keeps driving the output until the handover switches to the other path.
- R6: At most one path enable is requested at any time. The new path is enabled only after the old path's enable is seen low. With unchanged divider fields, a switch adds no output pulse or gap shorter than the shortest source half period.
- R7: If the source that the idle path currently selects is stopped, a write stalls with busy held at 1. It completes once that source runs again.
- R8: Writing the same index twice leaves both paths on that source. A later switch then completes even if the previously used source is stopped.
- R9: Writing the gate bit as 0 stops the output clock: no rising edges appear. Writing it as 1 restores the divided clock.
- R10: With the pre-divider parameter set to 0, the pre field has no effect on the output period, which is the source period times (post + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Register-port and control clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset for every domain |
| wr_en | input | 1 | Write strobe for the target record |
| wr_sel | input | SEL_W | Target source index |
| wr_gate | input | 1 | Output gate enable |
| wr_pre | input | PRE_W | Pre-divider value (divide by value+1) |
| wr_post | input | POST_W | Post-divider value (divide by value+1) |
| rd_sel | output | SEL_W | Source index of the active path |
| rd_gate | output | 1 | Gate enable last written |
| rd_pre | output | PRE_W | Pre-divider value last written |
| rd_post | output | POST_W | Post-divider value last written |
| rd_busy | output | 1 | Handover in progress |
| clk_in | input | N_IN | Source clocks |
| clk_out | output | 1 | Divided and gated output clock |

## Verification
Busy must be high at the first falling register-clock edge after the write strobe is taken, and the bench samples it there. The read-back index is only defined once busy has fallen, so the bench polls busy on falling edges and reads the port after it drops. Output periods settle one post-divider cycle after the handover, so each measurement waits for four fresh output rising edges after busy falls and uses the last interval. The stall is judged after 300 register cycles with busy still high, and the output clock is measured during that same stall.

// File: rtl/clk_slice_pkg.sv
package clk_slice_pkg;
    timeunit 1ns;
    timeprecision 1ns;

    // Handover sequencer states; order of the sequence is behaviour.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for a target write
        ST_LOAD  = 2'd1,  // idle path captures new select on its current source
        ST_DROP  = 2'd2,  // active path enable falling
        ST_RAISE = 2'd3   // new path enable settling
    } slice_state_e;
endpackage

// File: rtl/clk_slice_div.sv
module clk_slice_div #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] div_i,   // divide by div_i + 1
    output logic         clk_o
);
    timeunit 1ns;
    timeprecision 1ns;

    logic [W-1:0] cnt_d, cnt_q;
    logic         out_d, out_q;
    logic [W:0]   half;

    always_comb begin
        half  = ({1'b0, div_i} + (W+1)'(2)) >> 1;
        cnt_d = (cnt_q >= div_i) ? '0 : cnt_q + W'(1);
        out_d = ({1'b0, cnt_d} < half);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    assign clk_o = (div_i == '0) ? clk_i : out_q;
endmodule

// File: rtl/clk_slice_path.sv
module clk_slice_path #(
    parameter int N_IN    = 8,
    parameter int SEL_W   = 3,
    parameter int PRE_W   = 3,
    parameter bit HAS_PRE = 1'b1
) (
    input  logic [N_IN-1:0]  clk_in,
    input  logic             rst_ni,
    input  logic             load_tgl_i,   // toggles to request a reload
    input  logic [SEL_W-1:0] load_sel_i,
    input  logic [PRE_W-1:0] load_pre_i,
    input  logic             en_req_i,
    output logic             ack_tgl_o,    // follows load_tgl_i once loaded
    output logic             en_o,
    output logic             clk_o
);
    timeunit 1ns;
    timeprecision 1ns;

    logic [SEL_W-1:0] sel_q;
    logic [PRE_W-1:0] pre_q;
    logic             tgl_m_q, tgl_s_q, seen_q;
    logic             pclk, dclk;
    logic             en_m_q, en_s_q;

    // Source currently feeding this path; the select register is clocked by it.
    assign pclk = clk_in[sel_q];

    always_ff @(posedge pclk or negedge rst_ni) begin
        if (!rst_ni) begin
            tgl_m_q <= 1'b0;
            tgl_s_q <= 1'b0;
            seen_q  <= 1'b0;
            sel_q   <= '0;
            pre_q   <= '0;
        end else begin
            tgl_m_q <= load_tgl_i;
            tgl_s_q <= tgl_m_q;
            if (tgl_s_q != seen_q) begin
                seen_q <= tgl_s_q;
                sel_q  <= load_sel_i;
                pre_q  <= load_pre_i;
            end
        end
    end

    assign ack_tgl_o = seen_q;

    if (HAS_PRE) begin : g_pre
        clk_slice_div #(.W(PRE_W)) u_pre (
            .clk_i  (pclk),
            .rst_ni (rst_ni),
            .div_i  (pre_q),
            .clk_o  (dclk)
        );
    end else begin : g_nopre
        logic unused_pre;
        assign unused_pre = ^pre_q;
        assign dclk = pclk;
    end

    // Enable moves only while the divided clock is low.
    always_ff @(negedge dclk or negedge rst_ni) begin
        if (!rst_ni) begin
            en_m_q <= 1'b0;
            en_s_q <= 1'b0;
        end else begin
            en_m_q <= en_req_i;
            en_s_q <= en_m_q;
        end
    end

    assign en_o  = en_s_q;
    assign clk_o = dclk & en_s_q;
endmodule

// File: rtl/clk_root_slice.sv
module clk_root_slice
    import clk_slice_pkg::*;
#(
    parameter int N_IN        = 8,
    parameter int PRE_W       = 3,
    parameter int POST_W      = 6,
    parameter bit HAS_PRE_DIV = 1'b1,
    localparam int SEL_W      = $clog2(N_IN)
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_gate,
    input  logic [PRE_W-1:0]  wr_pre,
    input  logic [POST_W-1:0] wr_post,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              rd_gate,
    output logic [PRE_W-1:0]  rd_pre,
    output logic [POST_W-1:0] rd_post,
    output logic              rd_busy,
    input  logic [N_IN-1:0]   clk_in,
    output logic              clk_out
);
    timeunit 1ns;
    timeprecision 1ns;

    localparam int N_PATH = 2;

    typedef struct packed {
        slice_state_e                   state;
        logic                           ptr;      // 0: path A active, 1: path B
        logic [N_PATH-1:0][SEL_W-1:0]   sel_sh;   // shadow of each path select
        logic [SEL_W-1:0]               new_sel;
        logic [N_PATH-1:0]              load_tgl;
        logic [N_PATH-1:0]              en_req;
        logic                           gate;
        logic [PRE_W-1:0]               pre;
        logic [POST_W-1:0]              post;
    } ctl_t;

    ctl_t d, q;

    logic [N_PATH-1:0] ack_raw, en_raw, pout;
    logic [N_PATH-1:0] ack_m_q, ack_s_q, en_m_q, en_s_q;
    logic              idle;
    logic              clk_mid;

    assign idle = ~q.ptr;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (wr_en) begin
                    d.new_sel        = wr_sel;
                    d.gate           = wr_gate;
                    d.pre            = wr_pre;
                    d.post           = wr_post;
                    d.load_tgl[idle] = ~q.load_tgl[idle];
                    d.state          = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (ack_s_q[idle] == q.load_tgl[idle]) begin
                    d.sel_sh[idle]  = q.new_sel;
                    d.en_req[q.ptr] = 1'b0;
                    d.state         = ST_DROP;
                end
            end
            ST_DROP: begin
                if (!en_s_q[q.ptr]) begin
                    d.ptr          = idle;
                    d.en_req[idle] = q.gate;
                    d.state        = ST_RAISE;
                end
            end
            ST_RAISE: begin
                if (en_s_q[q.ptr] == q.en_req[q.ptr]) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            q.state    <= ST_RAISE;   // wait for path A to come up
            q.ptr      <= 1'b0;
            q.sel_sh   <= '0;
            q.new_sel  <= '0;
            q.load_tgl <= '0;
            q.en_req   <= N_PATH'(1);
            q.gate     <= 1'b1;
            q.pre      <= '0;
            q.post     <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            ack_m_q <= '0;
            ack_s_q <= '0;
            en_m_q  <= '0;
            en_s_q  <= '0;
        end else begin
            ack_m_q <= ack_raw;
            ack_s_q <= ack_m_q;
            en_m_q  <= en_raw;
            en_s_q  <= en_m_q;
        end
    end

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        clk_slice_path #(
            .N_IN    (N_IN),
            .SEL_W   (SEL_W),
            .PRE_W   (PRE_W),
            .HAS_PRE (HAS_PRE_DIV)
        ) u_path (
            .clk_in     (clk_in),
            .rst_ni     (sys_rst_n),
            .load_tgl_i (q.load_tgl[p]),
            .load_sel_i (q.new_sel),
            .load_pre_i (q.pre),
            .en_req_i   (q.en_req[p]),
            .ack_tgl_o  (ack_raw[p]),
            .en_o       (en_raw[p]),
            .clk_o      (pout[p])
        );
    end

    // Disabled paths sit low, so an OR is the final path mux.
    assign clk_mid = |pout;

    clk_slice_div #(.W(POST_W)) u_post (
        .clk_i  (clk_mid),
        .rst_ni (sys_rst_n),
        .div_i  (q.post),
        .clk_o  (clk_out)
    );

    assign rd_sel  = q.sel_sh[q.ptr];
    assign rd_gate = q.gate;
    assign rd_pre  = q.pre;
    assign rd_post = q.post;
    assign rd_busy = (q.state != ST_IDLE);

    AST_WRITE_RAISES_BUSY: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_en && !rd_busy) |=> rd_busy) else $error("busy missing after write"); // R2

    AST_DONE_SHOWS_TARGET: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $fell(rd_busy) |-> (rd_sel == q.new_sel)) else $error("wrong index at end"); // R2

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (rd_busy && wr_en) |=> ($stable(rd_post) && $stable(rd_gate) && $stable(rd_pre)))
        else $error("write taken while busy"); // R4

    AST_ACTIVE_SEL_KEPT: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (q.state == ST_LOAD) |=> $stable(q.sel_sh[q.ptr])) else $error("active select moved"); // R5

    AST_SINGLE_ENABLE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !(q.en_req[0] && q.en_req[1])) else $error("both paths requested"); // R6

    AST_A_AFTER_B_OFF: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(q.en_req[0]) |-> !en_s_q[1]) else $error("A raised while B on"); // R6

    AST_B_AFTER_A_OFF: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(q.en_req[1]) |-> !en_s_q[0]) else $error("B raised while A on"); // R6
endmodule

// File: tb/clk_root_slice_bench.sv
module clk_root_slice_bench;
    timeunit 1ns;
    timeprecision 1ns;

    localparam int SYS_HALF = 5;          // register clock period 10 ns
    localparam int N_IN     = 8;
    localparam int SEL_W    = 3;
    localparam int PRE_W    = 3;
    localparam int POST_W   = 6;

    logic              sys_clk = 1'b0;
    logic              sys_rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic              wr_gate = 1'b1;
    logic [PRE_W-1:0]  wr_pre = '0;
    logic [POST_W-1:0] wr_post = '0;
    logic [N_IN-1:0]   src = '0;
    logic [N_IN-1:0]   run = '1;

    logic [SEL_W-1:0]  sel_m, sel_c;
    logic              gate_m, gate_c, busy_m, busy_c, out_m, out_c;
    logic [PRE_W-1:0]  pre_m, pre_c;
    logic [POST_W-1:0] post_m, post_c;

    always #(SYS_HALF) sys_clk = ~sys_clk;

    // Source i has half period 2+i ns, so period 4+2i ns.
    for (genvar g = 0; g < N_IN; g++) begin : g_src
        always begin
            #(2 + g);
            if (run[g]) src[g] = ~src[g];
        end
    end

    clk_root_slice u_clk_root_slice (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_gate(wr_gate), .wr_pre(wr_pre), .wr_post(wr_post), .rd_sel(sel_m),
        .rd_gate(gate_m), .rd_pre(pre_m), .rd_post(post_m), .rd_busy(busy_m),
        .clk_in(src), .clk_out(out_m));

    clk_root_slice #(.HAS_PRE_DIV(1'b0)) u_clk_root_slice_core (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_gate(wr_gate), .wr_pre(wr_pre), .wr_post(wr_post), .rd_sel(sel_c),
        .rd_gate(gate_c), .rd_pre(pre_c), .rd_post(post_c), .rd_busy(busy_c),
        .clk_in(src), .clk_out(out_c));

    int n_chk = 0;
    int n_bad = 0;

    task automatic check_eq(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output edge trackers.
    int     m_n = 0, c_n = 0;
    longint m_last = 0, m_prev = 0, c_last = 0, c_prev = 0;
    always @(posedge out_m) begin m_prev = m_last; m_last = $time; m_n++; end
    always @(posedge out_c) begin c_prev = c_last; c_last = $time; c_n++; end

    // Pulse-width monitor for the handover sweep.
    bit     mon = 1'b0;
    longint g_last = 0;
    int     glitches = 0;
    always @(out_m) begin
        if (mon) begin
            if ($time - g_last < 2) glitches++;
            g_last = $time;
        end
    end

    function automatic longint src_per(input int s);
        return longint'(4 + 2 * s);
    endfunction

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge sys_clk);
            if (!busy_m && !busy_c) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic do_write(input int s, input int gt, input int pr, input int po,
                            input bit wait_done, input string req);
        bit ok;
        @(negedge sys_clk);
        wr_sel  = SEL_W'(s);
        wr_gate = gt[0];
        wr_pre  = PRE_W'(pr);
        wr_post = POST_W'(po);
        wr_en   = 1'b1;
        @(negedge sys_clk);
        wr_en   = 1'b0;
        check_eq({req, " R2 busy after write"}, longint'(busy_m), 1);
        if (wait_done) begin
            wait_idle(ok);
            check_eq({req, " R2 handover ends"}, longint'(ok), 1);
        end
    endtask

    task automatic measure(output longint pm, output longint pc);
        int sm = m_n;
        int sc = c_n;
        for (int i = 0; i < 20000 && (m_n < sm + 4 || c_n < sc + 4); i++) @(negedge sys_clk);
        pm = m_last - m_prev;
        pc = c_last - c_prev;
    endtask

    task automatic do_reset();
        bit ok;
        sys_rst_n = 1'b0;
        repeat (5) @(negedge sys_clk);
        sys_rst_n = 1'b1;
        wait_idle(ok);
        check_eq("R1 busy clears after reset", longint'(ok), 1);
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint pm, pc;
        int     s0;
        bit     ok;

        // R1: reset state.
        do_reset();
        check_eq("R1 rd_sel", longint'(sel_m), 0);
        check_eq("R1 rd_gate", longint'(gate_m), 1);
        check_eq("R1 rd_pre", longint'(pre_m), 0);
        check_eq("R1 rd_post", longint'(post_m), 0);
        measure(pm, pc);
        check_eq("R1 period main", pm, src_per(0));
        check_eq("R1 period core", pc, src_per(0));

        // R3 / R10 / R2: sweep of index, pre and post.
        for (int s = 0; s < N_IN; s++) begin
            for (int pr = 0; pr < 4; pr++) begin
                for (int po = 0; po < 4; po++) begin
                    do_write(s, 1, pr, po, 1'b1, "sweep");
                    check_eq("R2 rd_sel", longint'(sel_m), s);
                    check_eq("R2 rd_pre", longint'(pre_m), pr);
                    check_eq("R2 rd_post", longint'(post_m), po);
                    measure(pm, pc);
                    check_eq("R3 period", pm, src_per(s) * (pr + 1) * (po + 1));
                    check_eq("R10 core period", pc, src_per(s) * (po + 1));
                end
            end
        end

        // R3: largest divider fields.
        do_write(1, 1, 7, 63, 1'b1, "max");
        measure(pm, pc);
        check_eq("R3 max period", pm, src_per(1) * 8 * 64);
        check_eq("R10 max core period", pc, src_per(1) * 64);

        // R4: second write while busy is dropped.
        do_write(5, 1, 0, 0, 1'b0, "R4");
        @(negedge sys_clk);
        wr_sel = SEL_W'(6); wr_post = POST_W'(3); wr_en = 1'b1;
        @(negedge sys_clk);
        wr_en = 1'b0;
        wait_idle(ok);
        check_eq("R4 idle", longint'(ok), 1);
        check_eq("R4 rd_sel", longint'(sel_m), 5);
        check_eq("R4 rd_post", longint'(post_m), 0);
        measure(pm, pc);
        check_eq("R4 period", pm, src_per(5));

        // R6: switch through every source with fixed dividers.
        do_write(0, 1, 1, 1, 1'b1, "R6 prime");
        do_write(1, 1, 1, 1, 1'b1, "R6 prime");
        g_last = $time - 100;
        mon = 1'b1;
        for (int s = 0; s < N_IN; s++) begin
            do_write(s, 1, 1, 1, 1'b1, "R6");
            measure(pm, pc);
            check_eq("R6 period", pm, src_per(s) * 4);
        end
        mon = 1'b0;
        check_eq("R6 short pulses", longint'(glitches), 0);

        // R9: gate off and on again.
        do_write(3, 0, 0, 0, 1'b1, "R9");
        check_eq("R9 rd_gate", longint'(gate_m), 0);
        s0 = m_n;
        repeat (200) @(negedge sys_clk);
        check_eq("R9 no edges main", longint'(m_n - s0), 0);
        do_write(3, 1, 0, 0, 1'b1, "R9");
        measure(pm, pc);
        check_eq("R9 restored period", pm, src_per(3));

        // R5 / R7: stale source on the idle path stalls the write.
        do_reset();
        do_write(1, 1, 0, 0, 1'b1, "R5");
        run[0] = 1'b0;
        do_write(2, 1, 0, 0, 1'b0, "R7");
        repeat (300) @(negedge sys_clk);
        check_eq("R7 busy held", longint'(busy_m), 1);
        check_eq("R5 active index kept", longint'(sel_m), 1);
        measure(pm, pc);
        check_eq("R5 active path drives", pm, src_per(1));
        run[0] = 1'b1;
        wait_idle(ok);
        check_eq("R7 resumes", longint'(ok), 1);
        check_eq("R7 rd_sel", longint'(sel_m), 2);
        measure(pm, pc);
        check_eq("R7 period", pm, src_per(2));

        // R8: double write parks both paths on one source.
        do_reset();
        do_write(1, 1, 0, 0, 1'b1, "R8");
        do_write(1, 1, 0, 0, 1'b1, "R8");
        run[0] = 1'b0;
        do_write(2, 1, 0, 0, 1'b1, "R8");
        check_eq("R8 rd_sel", longint'(sel_m), 2);
        measure(pm, pc);
        check_eq("R8 period", pm, src_per(2));
        run[0] = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule